// File: doc/BRIEF.md
# Speculative Assert Misspeculation Monitor

This block watches the stream of fire events coming from speculative asserts and decides when one of them fires often enough, relative to how much work runs between fires, that it should be switched off. Each fire event carries an assert identifier and the current value of an external sample counter. The sample counter advances at a fixed period while its code runs, so the counter serves as a coarse measure of elapsed execution. For each identifier the block holds a small fire count, a stored copy of the sample value and a disabled flag. Two sample values are treated as close when they agree once their low bits are discarded. A run of close fires that grows past the local limit produces a one-cycle disable pulse carrying that identifier.

A separate window controller counts all valid fires over a fixed number of cycles and then sets the two knobs of the local comparison. When the whole system fires too often it tightens them: first it widens the sample shift, and once the shift is at its ceiling it lowers the local limit. When fire traffic is moderate it relaxes them in the reverse order. The controller is a two-state machine. In COUNT the window counter runs and fires are tallied. At the last cycle of the window the COUNT-to-JUDGE transition is taken. JUDGE lasts one cycle: it applies the adjustment, restarts the tally, and then takes the JUDGE-to-COUNT transition. A full period is therefore WIN_LEN + 1 cycles. Software re-enables a disabled identifier through a clear request.

Top module: `spec_assert_monitor`

## Requirements
- R1: After reset, dis_vld is 0, cur_shift is 0 and cur_lthr equals LTHR_DEF (default 8).
- R2: A fire whose sample, XORed with the stored sample and shifted right by cur_shift, is nonzero sets that identifier's count to 1 and stores the new sample. It raises no disable.
- R3: A fire whose shifted XOR is zero adds one to the count. If the new count exceeds cur_lthr, dis_vld is 1 with dis_id equal to the identifier in the cycle after the fire, for exactly that cycle, and the identifier becomes disabled. Otherwise the new count is stored.
- R4: cur_shift discards the low bits of the comparison. Samples 8 and 9 are close when the shift is 1 and not close when it is 0.
- R5: A disabled identifier ignores its fires and produces no pulse. A clear request (clr_vld with clr_id) re-enables it with count 0 and stored sample 0. A clear takes priority over a fire to the same identifier in the same cycle.
- R6: In JUDGE, when more than GTHR (default 16) valid fires were counted in the window, cur_shift rises by 1 if it is below SHIFT_MAX. Otherwise cur_lthr falls by 1 if it is above 0.
- R7: In JUDGE, when at most GTHR fires were counted, cur_lthr rises by 1 if it is below LTHR_DEF. Otherwise cur_shift falls by 1 if it is above 0. In either case the tally restarts, and a fire arriving in the JUDGE cycle is counted into the new window.
- R8: A window with exactly GTHR fires is judged as loosening.
- R9: Identifiers range over 0 to 30 (31 values). A fire with identifier 31 changes no state, produces no pulse and is not tallied.
- R10: The first JUDGE takes effect at the WIN_LEN+1-th clock edge after reset is released, and every further JUDGE follows WIN_LEN+1 edges later. Adjustments are visible from the cycle after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fire_vld | input | 1 | A fire event is present this cycle |
| fire_id | input | ID_W | Identifier of the fired assert |
| fire_sample | input | SAMP_W | Sample counter value at the fire |
| clr_vld | input | 1 | Software clear request |
| clr_id | input | ID_W | Identifier to re-enable |
| dis_vld | output | 1 | One-cycle disable pulse |
| dis_id | output | ID_W | Identifier being disabled |
| cur_shift | output | SH_W | Current sample comparison shift |
| cur_lthr | output | LT_W | Current local fire limit |

## Verification
The hardest case to reach is the chain of window decisions that ends with the shift at its ceiling and the local limit moving. That state needs several consecutive windows, each holding just over the global limit of fires. Those fires must also never disable the identifier that carries them. The bench runs a reduced window and a small shift ceiling. It drives 17 fires per window to one identifier, using samples that are multiples of 16, so they never compare close at any reachable shift. It then checks the effect of the lowered limit: a disable arrives one fire earlier than normal. After that it walks the knobs back down through quiet windows. A window with exactly 16 fires checks the boundary.

// File: rtl/sam_pkg.sv
package sam_pkg;

    // Window controller phases
    typedef enum logic {
        ST_COUNT = 1'b0,
        ST_JUDGE = 1'b1
    } win_state_e;

endpackage

// File: rtl/sam_entry_table.sv
module sam_entry_table #(
    parameter int ID_W     = 5,
    parameter int SAMP_W   = 16,
    parameter int SH_W     = 4,
    parameter int LT_W     = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fire_vld,
    input  logic [ID_W-1:0]   fire_id,
    input  logic [SAMP_W-1:0] fire_sample,
    input  logic              clr_vld,
    input  logic [ID_W-1:0]   clr_id,
    input  logic [SH_W-1:0]   shift,
    input  logic [LT_W-1:0]   lthr,
    output logic              dis_vld,
    output logic [ID_W-1:0]   dis_id
);

    localparam int NUM_IDS = (1 << ID_W) - 1;
    localparam int CNT_W   = LT_W + 1;

    logic [CNT_W-1:0]  cnt_q  [NUM_IDS];
    logic [SAMP_W-1:0] samp_q [NUM_IDS];
    logic [NUM_IDS-1:0] off_q;

    logic              in_range;
    logic [ID_W-1:0]   sel;
    logic              hit;
    logic [SAMP_W-1:0] diff;
    logic              close;
    logic [CNT_W-1:0]  nxt_cnt;
    logic              trip;

    // Evaluate the addressed entry
    always_comb begin
        in_range = (fire_id != {ID_W{1'b1}});
        sel      = in_range ? fire_id : '0;
        hit      = fire_vld && in_range && !off_q[sel]
                   && !(clr_vld && clr_id == fire_id);
        diff     = (fire_sample ^ samp_q[sel]) >> shift;
        close    = (diff == '0);
        nxt_cnt  = cnt_q[sel] + 1'b1;
        trip     = close && (nxt_cnt > {1'b0, lthr});
    end

    // One storage slot per identifier
    for (genvar g = 0; g < NUM_IDS; g++) begin : g_entry
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                cnt_q[g]  <= '0;
                samp_q[g] <= '0;
                off_q[g]  <= 1'b0;
            end else if (clr_vld && clr_id == ID_W'(g)) begin
                cnt_q[g]  <= '0;
                samp_q[g] <= '0;
                off_q[g]  <= 1'b0;
            end else if (hit && sel == ID_W'(g)) begin
                if (!close) begin
                    cnt_q[g]  <= CNT_W'(1);
                    samp_q[g] <= fire_sample;
                end else if (trip) begin
                    off_q[g]  <= 1'b1;
                end else begin
                    cnt_q[g]  <= nxt_cnt;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dis_vld <= 1'b0;
            dis_id  <= '0;
        end else begin
            dis_vld <= hit && trip;
            dis_id  <= (hit && trip) ? fire_id : '0;
        end
    end

endmodule

// File: rtl/sam_window_ctrl.sv
module sam_window_ctrl
    import sam_pkg::*;
#(
    parameter int WIN_LEN   = 100_000_000,
    parameter int GTHR      = 16,
    parameter int SHIFT_MAX = 8,
    parameter int LTHR_DEF  = 8,
    parameter int SH_W      = 4,
    parameter int LT_W      = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            fire_inc,
    output logic [SH_W-1:0] shift,
    output logic [LT_W-1:0] lthr
);

    localparam int WC_W   = (WIN_LEN > 1) ? $clog2(WIN_LEN) : 1;
    localparam int GC_MAX = GTHR + 1;
    localparam int GC_W   = $clog2(GC_MAX + 1);

    win_state_e      state_q, state_d;
    logic [WC_W-1:0] wcnt_q;
    logic [GC_W-1:0] gcnt_q;
    logic            over;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_COUNT;
        else        state_q <= state_d;
    end

    // Transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_COUNT: if (wcnt_q == WC_W'(WIN_LEN - 1)) state_d = ST_JUDGE;
            ST_JUDGE: state_d = ST_COUNT;
        endcase
    end

    assign over = (gcnt_q > GC_W'(GTHR));

    // Datapath owned by the states
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wcnt_q <= '0;
            gcnt_q <= '0;
            shift  <= '0;
            lthr   <= LT_W'(LTHR_DEF);
        end else begin
            unique case (state_q)
                ST_COUNT: begin
                    if (wcnt_q == WC_W'(WIN_LEN - 1)) wcnt_q <= '0;
                    else                              wcnt_q <= wcnt_q + 1'b1;
                    if (fire_inc && gcnt_q != GC_W'(GC_MAX))
                        gcnt_q <= gcnt_q + 1'b1;
                end
                ST_JUDGE: begin
                    gcnt_q <= fire_inc ? GC_W'(1) : '0;
                    if (over) begin
                        if (shift < SH_W'(SHIFT_MAX))  shift <= shift + 1'b1;
                        else if (lthr != '0)           lthr  <= lthr - 1'b1;
                    end else begin
                        if (lthr < LT_W'(LTHR_DEF))    lthr  <= lthr + 1'b1;
                        else if (shift != '0)          shift <= shift - 1'b1;
                    end
                end
            endcase
        end
    end

endmodule

// File: rtl/spec_assert_monitor.sv
module spec_assert_monitor #(
    parameter int ID_W      = 5,
    parameter int SAMP_W    = 16,
    parameter int WIN_LEN   = 100_000_000,
    parameter int GTHR      = 16,
    parameter int SHIFT_MAX = 8,
    parameter int LTHR_DEF  = 8,
    parameter int SH_W      = $clog2(SHIFT_MAX + 1),
    parameter int LT_W      = $clog2(LTHR_DEF + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fire_vld,
    input  logic [ID_W-1:0]   fire_id,
    input  logic [SAMP_W-1:0] fire_sample,
    input  logic              clr_vld,
    input  logic [ID_W-1:0]   clr_id,
    output logic              dis_vld,
    output logic [ID_W-1:0]   dis_id,
    output logic [SH_W-1:0]   cur_shift,
    output logic [LT_W-1:0]   cur_lthr
);

    logic fire_inc;

    assign fire_inc = fire_vld && (fire_id != {ID_W{1'b1}});

    sam_window_ctrl #(
        .WIN_LEN   (WIN_LEN),
        .GTHR      (GTHR),
        .SHIFT_MAX (SHIFT_MAX),
        .LTHR_DEF  (LTHR_DEF),
        .SH_W      (SH_W),
        .LT_W      (LT_W)
    ) i_win (
        .clk      (clk),
        .rst_n    (rst_n),
        .fire_inc (fire_inc),
        .shift    (cur_shift),
        .lthr     (cur_lthr)
    );

    sam_entry_table #(
        .ID_W   (ID_W),
        .SAMP_W (SAMP_W),
        .SH_W   (SH_W),
        .LT_W   (LT_W)
    ) i_tab (
        .clk         (clk),
        .rst_n       (rst_n),
        .fire_vld    (fire_vld),
        .fire_id     (fire_id),
        .fire_sample (fire_sample),
        .clr_vld     (clr_vld),
        .clr_id      (clr_id),
        .shift       (cur_shift),
        .lthr        (cur_lthr),
        .dis_vld     (dis_vld),
        .dis_id      (dis_id)
    );

endmodule

// File: rtl/sam_checker.sv
module sam_checker #(
    parameter int ID_W      = 5,
    parameter int SHIFT_MAX = 8,
    parameter int LTHR_DEF  = 8,
    parameter int SH_W      = 4,
    parameter int LT_W      = 4
) (
    input logic            clk,
    input logic            rst_n,
    input logic            fire_vld,
    input logic [ID_W-1:0] fire_id,
    input logic            dis_vld,
    input logic [ID_W-1:0] dis_id,
    input logic [SH_W-1:0] cur_shift,
    input logic [LT_W-1:0] cur_lthr
);

    AST_DIS_AFTER_FIRE: assert property (@(posedge clk) disable iff (!rst_n)
        dis_vld |-> ($past(fire_vld) && $past(fire_id) == dis_id)); // R3

    AST_DIS_ID_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        dis_vld |-> (dis_id != {ID_W{1'b1}})); // R9

    AST_SHIFT_CEIL: assert property (@(posedge clk) disable iff (!rst_n)
        cur_shift <= SH_W'(SHIFT_MAX)); // R6

    AST_LTHR_CEIL: assert property (@(posedge clk) disable iff (!rst_n)
        cur_lthr <= LT_W'(LTHR_DEF)); // R7

    AST_ONE_KNOB: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(cur_shift) |-> $stable(cur_lthr)); // R7

endmodule

bind spec_assert_monitor sam_checker #(
    .ID_W      (ID_W),
    .SHIFT_MAX (SHIFT_MAX),
    .LTHR_DEF  (LTHR_DEF),
    .SH_W      (SH_W),
    .LT_W      (LT_W)
) i_sam_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .fire_vld  (fire_vld),
    .fire_id   (fire_id),
    .dis_vld   (dis_vld),
    .dis_id    (dis_id),
    .cur_shift (cur_shift),
    .cur_lthr  (cur_lthr)
);

// File: tb/test_spec_assert_monitor.sv
module test_spec_assert_monitor;

    localparam int ID_W      = 5;
    localparam int SAMP_W    = 16;
    localparam int WIN_LEN   = 64;
    localparam int PERIOD    = WIN_LEN + 1;
    localparam int SHIFT_MAX = 2;
    localparam int LTHR_DEF  = 8;
    localparam int SH_W      = $clog2(SHIFT_MAX + 1);
    localparam int LT_W      = $clog2(LTHR_DEF + 1);

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              fire_vld = 1'b0;
    logic [ID_W-1:0]   fire_id = '0;
    logic [SAMP_W-1:0] fire_sample = '0;
    logic              clr_vld = 1'b0;
    logic [ID_W-1:0]   clr_id = '0;
    logic              dis_vld;
    logic [ID_W-1:0]   dis_id;
    logic [SH_W-1:0]   cur_shift;
    logic [LT_W-1:0]   cur_lthr;

    int n_chk  = 0;
    int n_fail = 0;
    int cyc    = 0;
    bit done   = 0;
    bit seen   = 0;

    bit          exp_q [$];
    int          id_q  [$];
    string       tag_q [$];

    always #10 clk = ~clk;

    spec_assert_monitor #(
        .ID_W      (ID_W),
        .SAMP_W    (SAMP_W),
        .WIN_LEN   (WIN_LEN),
        .GTHR      (16),
        .SHIFT_MAX (SHIFT_MAX),
        .LTHR_DEF  (LTHR_DEF)
    ) i_spec_assert_monitor (
        .clk         (clk),
        .rst_n       (rst_n),
        .fire_vld    (fire_vld),
        .fire_id     (fire_id),
        .fire_sample (fire_sample),
        .clr_vld     (clr_vld),
        .clr_id      (clr_id),
        .dis_vld     (dis_vld),
        .dis_id      (dis_id),
        .cur_shift   (cur_shift),
        .cur_lthr    (cur_lthr)
    );

    always @(posedge clk) begin
        if (rst_n) cyc <= cyc + 1;
        seen <= fire_vld;
    end

    task automatic check(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // Monitor: pops one expected item per fire presented on the last edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (seen) begin
                if (exp_q.size() == 0) begin
                    check("scoreboard underflow", 1, 0);
                end else begin
                    bit    e;
                    int    i;
                    string t;
                    e = exp_q.pop_front();
                    i = id_q.pop_front();
                    t = tag_q.pop_front();
                    check({t, " dis_vld"}, int'(dis_vld), int'(e));
                    if (e) check({t, " dis_id"}, int'(dis_id), i);
                end
            end else if (dis_vld) begin
                check("R3 stray pulse", 1, 0);
            end
        end
    end

    // Driver: present one fire for one edge and queue the expected result
    task automatic fire(input int id, input int samp, input bit exp, input string tag);
        fire_vld    = 1'b1;
        fire_id     = ID_W'(id);
        fire_sample = SAMP_W'(samp);
        exp_q.push_back(exp);
        id_q.push_back(id);
        tag_q.push_back(tag);
        @(negedge clk);
        fire_vld = 1'b0;
    endtask

    task automatic clear(input int id);
        clr_vld = 1'b1;
        clr_id  = ID_W'(id);
        @(negedge clk);
        clr_vld = 1'b0;
    endtask

    task automatic goto_win(input int w);
        while (cyc < w * PERIOD + 2) @(negedge clk);
    endtask

    task automatic burst(input int n, input string tag);
        for (int k = 0; k < n; k++) fire(20, (k + 1) * 16, 1'b0, tag);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 dis_vld", int'(dis_vld), 0);
        check("R1 shift", int'(cur_shift), 0);
        check("R1 lthr", int'(cur_lthr), LTHR_DEF);

        // Window 0: 19 valid fires -> tighten
        fire(3, 5, 1'b0, "R2 first fire");
        for (int k = 0; k < 7; k++) fire(3, 5, 1'b0, "R3 below limit");
        fire(3, 5, 1'b1, "R3 ninth fire");
        fire(3, 5, 1'b0, "R5 ignored while off");
        fire(31, 5, 1'b0, "R9 id 31");
        clear(3);
        fire(3, 5, 1'b0, "R5 after clear");
        for (int k = 0; k < 7; k++) fire(3, 5, 1'b0, "R5 recount");
        fire(3, 5, 1'b1, "R5 disable again");

        goto_win(1);
        check("R10 R6 shift up", int'(cur_shift), 1);
        check("R6 lthr kept", int'(cur_lthr), 8);
        fire(7, 8, 1'b0, "R4 first");
        for (int k = 0; k < 7; k++) fire(7, (k % 2 == 0) ? 9 : 8, 1'b0, "R4 close");
        fire(7, 9, 1'b1, "R4 shift one trips");

        goto_win(2);
        check("R7 shift down", int'(cur_shift), 0);
        for (int k = 0; k < 10; k++) fire(9, (k % 2 == 0) ? 8 : 9, 1'b0, "R4 shift zero");

        goto_win(3);
        burst(16, "R8 burst16");
        goto_win(4);
        check("R8 exactly limit", int'(cur_shift), 0);
        burst(17, "R6 burst17");
        goto_win(5);
        check("R6 shift 1", int'(cur_shift), 1);
        burst(17, "R6 burst17");
        goto_win(6);
        check("R6 shift max", int'(cur_shift), SHIFT_MAX);
        burst(17, "R6 burst17");
        goto_win(7);
        check("R6 lthr down", int'(cur_lthr), 7);
        check("R6 shift held", int'(cur_shift), SHIFT_MAX);
        fire(11, 64, 1'b0, "R3 lowered first");
        for (int k = 0; k < 6; k++) fire(11, 65, 1'b0, "R3 lowered close");
        fire(11, 66, 1'b1, "R3 lowered limit trips");

        goto_win(8);
        check("R7 lthr up", int'(cur_lthr), 8);
        check("R7 shift kept", int'(cur_shift), SHIFT_MAX);
        goto_win(9);
        check("R7 shift down from max", int'(cur_shift), 1);
        check("R7 lthr default", int'(cur_lthr), 8);

        @(negedge clk);
        check("scoreboard drained", exp_q.size(), 0);
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule